// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers characters from one idle-high asynchronous serial line. It runs on a clock sixteen times the bit rate. A high-to-low edge on the line starts a character. The block confirms the start bit at mid-bit, then samples each data bit, the optional parity bit and the first stop bit at the centre of its bit period. The completed character is copied into a single receive buffer register, right-justified. A data-ready flag and three error flags (parity, framing, overrun) are updated at the same moment.

The character format comes from a control register. The register follows its inputs while the load input is high and keeps its value while load is low. The format covers:

- five to eight data bits;
- a parity check that can be inhibited;
- odd or even parity when the check is enabled.

The receiving host reads the buffer and acknowledges it by pulsing an active-low clear input, which drops the data-ready flag. Master reset clears every flag and leaves the last received character in the buffer. Two enable inputs gate the data outputs and the flag outputs; a disabled output reads zero.

Top module: `uart_rx_core`

## Requirements
- R1: With one bit period equal to 16 clocks, an 8-bit character sent least significant bit first appears unchanged on `rx_data`.
- R2: `len_sel` picks the character length as 5 + `len_sel` bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8.
- R3: A character shorter than 8 bits occupies `rx_data` from bit 0 upward, and the unused upper bits read 0.
- R4: With parity enabled, `par_even`=1 checks even parity and `par_even`=0 checks odd parity. The parity bit follows the last data bit. `err_parity` goes high for a mismatch and low for a match.
- R5: With `par_inhibit`=1, no parity bit is expected: the first stop bit directly follows the data. `err_parity` stays 0.
- R6: `err_frame` is 1 after a character whose first stop bit was sampled low, and 0 after a character whose first stop bit was high.
- R7: `data_ready` goes high when a character enters the buffer. A one-clock low pulse on `dr_clear_n` drives it low.
- R8: `err_overrun` goes high when a character enters the buffer while `data_ready` is still high. It goes low when a character enters the buffer with `data_ready` low.
- R9: Master reset `rst` clears `data_ready`, `err_parity`, `err_frame` and `err_overrun`. It leaves the buffer contents unchanged.
- R10: If the line is high again when sampled 8 clocks after a falling edge, no character is received. A valid character that follows is received normally.
- R11: With `buf_oe`=0, `rx_data` reads 0. With `flag_oe`=0, the four flag outputs read 0. Neither enable changes the stored state.
- R12: The control word is captured while `cfg_load` is high and held while it is low. Format inputs that change while `cfg_load` is low do not affect reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, 16x the bit rate |
| rst | input | 1 | Master reset, active high |
| rx_line | input | 1 | Serial input, idle high |
| cfg_load | input | 1 | Control register load, high = follow inputs |
| len_sel | input | 2 | Character length select (5 + value) |
| par_inhibit | input | 1 | 1 = no parity bit, parity flag held low |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| dr_clear_n | input | 1 | Active-low clear of data_ready |
| buf_oe | input | 1 | Enables rx_data |
| flag_oe | input | 1 | Enables the four flag outputs |
| rx_data | output | 8 | Receive buffer, right-justified |
| data_ready | output | 1 | Character received and not yet cleared |
| err_parity | output | 1 | Parity mismatch on last character |
| err_frame | output | 1 | First stop bit was low on last character |
| err_overrun | output | 1 | Last character overwrote an unread one |

## Verification
The hardest condition to reach is a false start bit: a falling edge that disappears before the mid-bit confirmation point. The stimulus holds the line low for only four clocks and then returns it high. It then checks that `data_ready` stays low, and it sends a valid character straight afterwards to show the receiver went back to idle. A second hard case is a character whose stop bit is low, followed by a master reset. This is the only way to see at the ports that the error flags clear while the buffer keeps that character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
   localparam int DATA_MAX = 8;
   localparam int DATA_MIN = 5;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_t;

   typedef struct packed {
      logic [1:0] len_sel;
      logic       par_inhibit;
      logic       par_even;
   } rx_cfg_t;

   typedef struct packed {
      logic [DATA_MAX-1:0] data;
      logic                perr;
      logic                ferr;
   } rx_char_t;
endpackage

// File: rtl/uart_rx_cfg.sv
module uart_rx_cfg
   import uart_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       load,
   input  logic [1:0] len_sel,
   input  logic       par_inhibit,
   input  logic       par_even,
   output rx_cfg_t    cfg
);
   rx_cfg_t cfg_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= '{len_sel: 2'd3, par_inhibit: 1'b1, par_even: 1'b0};
      end else if (load) begin
         cfg_q <= '{len_sel: len_sel, par_inhibit: par_inhibit, par_even: par_even};
      end
   end

   assign cfg = cfg_q;

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(cfg_q)) else $error("cfg changed without load"); // R12
endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
   import uart_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     rx_line,
   input  rx_cfg_t  cfg,
   output logic     done,
   output rx_char_t chr
);
   localparam int CW   = $clog2(OVS);
   localparam int HALF = OVS / 2;
   localparam int IW   = $clog2(DATA_MAX);

   if (OVS < 4) begin : g_bad_ovs
      $error("OVS must be at least 4");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic line;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign line = rx_line;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
         if (rst) sync_q <= '1;
         else     sync_q <= {sync_q[SYNC_STAGES-2+1-1:0], rx_line};
      end
      assign line = sync_q[SYNC_STAGES-1];
   end

   rx_state_t           state;
   logic [CW-1:0]       cnt;
   logic [IW-1:0]       idx;
   logic [DATA_MAX-1:0] shreg;
   logic                acc, line_prev, perr_q, ferr_q, done_q;
   logic [IW-1:0]       last_idx;
   logic                at_mid, at_bit;

   assign last_idx = IW'(DATA_MIN - 1) + IW'(cfg.len_sel);
   assign at_mid   = (cnt == CW'(HALF - 1));
   assign at_bit   = (cnt == CW'(OVS - 1));

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= RX_IDLE;
         cnt       <= '0;
         idx       <= '0;
         shreg     <= '0;
         acc       <= 1'b0;
         line_prev <= 1'b1;
         perr_q    <= 1'b0;
         ferr_q    <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         line_prev <= line;
         done_q    <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (line_prev && !line) begin
                  state <= RX_START;
                  cnt   <= '0;
               end
            end
            RX_START: begin
               if (at_mid) begin
                  cnt <= '0;
                  if (line) begin
                     state <= RX_IDLE;
                  end else begin
                     state  <= RX_DATA;
                     idx    <= '0;
                     shreg  <= '0;
                     acc    <= 1'b0;
                     perr_q <= 1'b0;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_DATA: begin
               if (at_bit) begin
                  cnt        <= '0;
                  shreg[idx] <= line;
                  acc        <= acc ^ line;
                  if (idx == last_idx) state <= cfg.par_inhibit ? RX_STOP : RX_PAR;
                  else                 idx   <= idx + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_PAR: begin
               if (at_bit) begin
                  cnt    <= '0;
                  perr_q <= cfg.par_even ? (acc ^ line) : ~(acc ^ line);
                  state  <= RX_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_STOP: begin
               if (at_bit) begin
                  cnt    <= '0;
                  ferr_q <= ~line;
                  if (cfg.par_inhibit) perr_q <= 1'b0;
                  done_q <= 1'b1;
                  state  <= RX_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   assign done = done_q;
   assign chr  = '{data: shreg, perr: perr_q, ferr: ferr_q};

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
      idx <= last_idx || state != RX_DATA) else $error("bit index overrun"); // R2
   AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
      done_q && cfg.len_sel == 2'd0 |-> shreg[DATA_MAX-1:DATA_MIN] == '0)
      else $error("upper bits not zero"); // R3
   AST_INHIBIT_NO_PERR: assert property (@(posedge clk) disable iff (rst)
      done_q && cfg.par_inhibit |-> !perr_q) else $error("parity error while inhibited"); // R5
   AST_FALSE_START: assert property (@(posedge clk) disable iff (rst)
      state == RX_START && at_mid && line |=> state == RX_IDLE && !done_q)
      else $error("false start not abandoned"); // R10
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
   import uart_rx_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  logic                done,
   input  rx_char_t            chr,
   input  logic                dr_clear_n,
   output logic [DATA_MAX-1:0] buf_data,
   output logic                dr,
   output logic                pe,
   output logic                fe,
   output logic                oe
);
   logic [DATA_MAX-1:0] buf_q;
   logic                dr_q, pe_q, fe_q, oe_q;

   always_ff @(posedge clk) begin
      if (done) buf_q <= chr.data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         dr_q <= 1'b0;
         pe_q <= 1'b0;
         fe_q <= 1'b0;
         oe_q <= 1'b0;
      end else if (done) begin
         dr_q <= 1'b1;
         oe_q <= dr_q;
         pe_q <= chr.perr;
         fe_q <= chr.ferr;
      end else if (!dr_clear_n) begin
         dr_q <= 1'b0;
      end
   end

   assign buf_data = buf_q;
   assign dr       = dr_q;
   assign pe       = pe_q;
   assign fe       = fe_q;
   assign oe       = oe_q;

   AST_DR_ON_XFER: assert property (@(posedge clk) disable iff (rst)
      done |=> dr_q) else $error("data ready not set"); // R7
   AST_DR_CLEAR: assert property (@(posedge clk) disable iff (rst)
      !done && !dr_clear_n |=> !dr_q) else $error("data ready not cleared"); // R7
   AST_NO_OVERRUN_LOST: assert property (@(posedge clk) disable iff (rst)
      done && dr_q |=> oe_q) else $error("overrun missed"); // R8
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
   import uart_rx_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       rx_line,
   input  logic       cfg_load,
   input  logic [1:0] len_sel,
   input  logic       par_inhibit,
   input  logic       par_even,
   input  logic       dr_clear_n,
   input  logic       buf_oe,
   input  logic       flag_oe,
   output logic [7:0] rx_data,
   output logic       data_ready,
   output logic       err_parity,
   output logic       err_frame,
   output logic       err_overrun
);
   rx_cfg_t             cfg;
   rx_char_t            chr;
   logic                done;
   logic [DATA_MAX-1:0] buf_data;
   logic                dr, pe, fe, oe;

   uart_rx_cfg u_cfg (
      .clk(clk), .rst(rst), .load(cfg_load), .len_sel(len_sel),
      .par_inhibit(par_inhibit), .par_even(par_even), .cfg(cfg)
   );

   uart_rx_sampler #(.OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_samp (
      .clk(clk), .rst(rst), .rx_line(rx_line), .cfg(cfg),
      .done(done), .chr(chr)
   );

   uart_rx_status u_stat (
      .clk(clk), .rst(rst), .done(done), .chr(chr), .dr_clear_n(dr_clear_n),
      .buf_data(buf_data), .dr(dr), .pe(pe), .fe(fe), .oe(oe)
   );

   assign rx_data     = buf_oe  ? buf_data : '0;
   assign data_ready  = flag_oe & dr;
   assign err_parity  = flag_oe & pe;
   assign err_frame   = flag_oe & fe;
   assign err_overrun = flag_oe & oe;
endmodule

// File: tb/uart_rx_core_bench.sv
module uart_rx_core_bench;
   localparam int CLK_PERIOD = 10;
   localparam int BIT_CLKS   = 16;

   logic       clk = 1'b0;
   logic       rst, rx_line, cfg_load, par_inhibit, par_even, dr_clear_n, buf_oe, flag_oe;
   logic [1:0] len_sel;
   logic [7:0] rx_data;
   logic       data_ready, err_parity, err_frame, err_overrun;
   int         n_tests = 0;
   int         n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_rx_core u_uart_rx_core (
      .clk(clk), .rst(rst), .rx_line(rx_line), .cfg_load(cfg_load),
      .len_sel(len_sel), .par_inhibit(par_inhibit), .par_even(par_even),
      .dr_clear_n(dr_clear_n), .buf_oe(buf_oe), .flag_oe(flag_oe),
      .rx_data(rx_data), .data_ready(data_ready), .err_parity(err_parity),
      .err_frame(err_frame), .err_overrun(err_overrun)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clks(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_cfg(input logic [1:0] l, input logic inh, input logic ev);
      len_sel = l; par_inhibit = inh; par_even = ev; cfg_load = 1'b1;
      clks(1);
      cfg_load = 1'b0;
      clks(1);
   endtask

   task automatic send_bit(input logic b);
      rx_line = b;
      clks(BIT_CLKS);
   endtask

   // LSB first; par_mode 0 none, 1 correct even/odd, 2 wrong parity
   task automatic send(input logic [7:0] d, input int nb, input int par_mode,
                       input logic ev, input logic stop_val);
      logic p;
      p = 1'b0;
      for (int i = 0; i < nb; i++) p ^= d[i];
      if (!ev) p = ~p;
      if (par_mode == 2) p = ~p;
      send_bit(1'b0);
      for (int i = 0; i < nb; i++) send_bit(d[i]);
      if (par_mode != 0) send_bit(p);
      send_bit(stop_val);
      rx_line = 1'b1;
      clks(2 * BIT_CLKS);
   endtask

   task automatic clear_dr;
      dr_clear_n = 1'b0;
      clks(1);
      dr_clear_n = 1'b1;
      clks(1);
   endtask

   task automatic t_reset;
      rst = 1'b1; clks(3); rst = 1'b0; clks(2);
      chk("R9 reset dr", data_ready, 0);
      chk("R9 reset flags", {err_parity, err_frame, err_overrun}, 0);
   endtask

   task automatic t_basic8;
      set_cfg(2'd3, 1'b1, 1'b0);
      send(8'hA5, 8, 0, 1'b0, 1'b1);
      chk("R1 data A5", rx_data, 8'hA5);
      chk("R7 dr set", data_ready, 1);
      chk("R6 no frame err", err_frame, 0);
      clear_dr();
      chk("R7 dr cleared", data_ready, 0);
      send(8'h3C, 8, 0, 1'b0, 1'b1);
      chk("R1 data 3C", rx_data, 8'h3C);
      clear_dr();
   endtask

   task automatic t_lengths;
      for (int l = 0; l < 3; l++) begin
         set_cfg(2'(l), 1'b1, 1'b0);
         send(8'hFF, 5 + l, 0, 1'b0, 1'b1);
         chk("R2 R3 length justify", rx_data, 32'((1 << (5 + l)) - 1));
         clear_dr();
      end
      set_cfg(2'd0, 1'b1, 1'b0);
      send(8'hF5, 5, 0, 1'b0, 1'b1);
      chk("R3 upper zero", rx_data, 8'h15);
      clear_dr();
   endtask

   task automatic t_parity;
      set_cfg(2'd3, 1'b0, 1'b1);
      send(8'h81, 8, 1, 1'b1, 1'b1);
      chk("R4 even ok", err_parity, 0);
      chk("R4 even data", rx_data, 8'h81);
      clear_dr();
      send(8'h81, 8, 2, 1'b1, 1'b1);
      chk("R4 even bad", err_parity, 1);
      clear_dr();
      set_cfg(2'd1, 1'b0, 1'b0);
      send(8'h2B, 6, 1, 1'b0, 1'b1);
      chk("R4 odd ok", err_parity, 0);
      chk("R4 odd data", rx_data, 8'h2B);
      clear_dr();
      send(8'h2B, 6, 2, 1'b0, 1'b1);
      chk("R4 odd bad", err_parity, 1);
      clear_dr();
   endtask

   task automatic t_inhibit;
      set_cfg(2'd2, 1'b1, 1'b1);
      send(8'h01, 7, 0, 1'b1, 1'b1);
      chk("R5 inhibit pe", err_parity, 0);
      chk("R5 inhibit fe", err_frame, 0);
      chk("R5 inhibit data", rx_data, 8'h01);
      clear_dr();
   endtask

   task automatic t_frame;
      set_cfg(2'd3, 1'b1, 1'b0);
      send(8'h5A, 8, 0, 1'b0, 1'b0);
      chk("R6 frame err", err_frame, 1);
      clear_dr();
      send(8'h11, 8, 0, 1'b0, 1'b1);
      chk("R6 frame ok", err_frame, 0);
      clear_dr();
   endtask

   task automatic t_overrun;
      set_cfg(2'd3, 1'b1, 1'b0);
      send(8'h10, 8, 0, 1'b0, 1'b1);
      chk("R8 no overrun", err_overrun, 0);
      send(8'h20, 8, 0, 1'b0, 1'b1);
      chk("R8 overrun", err_overrun, 1);
      chk("R8 newest data", rx_data, 8'h20);
      clear_dr();
      send(8'h30, 8, 0, 1'b0, 1'b1);
      chk("R8 overrun clears", err_overrun, 0);
      clear_dr();
   endtask

   task automatic t_mreset;
      set_cfg(2'd3, 1'b1, 1'b0);
      send(8'hC3, 8, 0, 1'b0, 1'b1);
      send(8'h6E, 8, 0, 1'b0, 1'b0);
      chk("R9 pre flags", {data_ready, err_frame, err_overrun}, 3'b111);
      rst = 1'b1; clks(2); rst = 1'b0; clks(2);
      chk("R9 flags clear", {data_ready, err_parity, err_frame, err_overrun}, 0);
      chk("R9 buffer kept", rx_data, 8'h6E);
   endtask

   task automatic t_false_start;
      set_cfg(2'd3, 1'b1, 1'b0);
      rx_line = 1'b0; clks(4); rx_line = 1'b1; clks(3 * BIT_CLKS);
      chk("R10 no char", data_ready, 0);
      send(8'h96, 8, 0, 1'b0, 1'b1);
      chk("R10 next char", rx_data, 8'h96);
      chk("R10 next dr", data_ready, 1);
      clear_dr();
   endtask

   task automatic t_oe;
      send(8'h44, 8, 0, 1'b0, 1'b1);
      send(8'h55, 8, 0, 1'b0, 1'b1);
      buf_oe = 1'b0; flag_oe = 1'b0; clks(1);
      chk("R11 data gated", rx_data, 0);
      chk("R11 flags gated", {data_ready, err_overrun}, 0);
      buf_oe = 1'b1; flag_oe = 1'b1; clks(1);
      chk("R11 state kept", {rx_data, data_ready, err_overrun}, {8'h55, 2'b11});
      clear_dr();
   endtask

   task automatic t_cfg_hold;
      set_cfg(2'd3, 1'b1, 1'b0);
      len_sel = 2'd0; par_inhibit = 1'b0; clks(2);
      send(8'hE7, 8, 0, 1'b0, 1'b1);
      chk("R12 held config data", rx_data, 8'hE7);
      chk("R12 held config pe", err_parity, 0);
      clear_dr();
   endtask

   initial begin
      rst = 1'b1; rx_line = 1'b1; cfg_load = 1'b0; len_sel = 2'd3;
      par_inhibit = 1'b1; par_even = 1'b0; dr_clear_n = 1'b1;
      buf_oe = 1'b1; flag_oe = 1'b1;
      t_reset();
      t_basic8();
      t_lengths();
      t_parity();
      t_inhibit();
      t_frame();
      t_overrun();
      t_mreset();
      t_false_start();
      t_oe();
      t_cfg_hold();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule